// File: doc/BRIEF.md
# Four-Stage Shift Register with Parallel Load and JK Serial Entry

This block is a small storage chain of flip-flops that either captures a whole word from parallel inputs or moves its contents one stage toward the far end. A single mode level chooses between the two actions. Both actions take effect on the rising clock edge. Every stage output is available in parallel, and the final stage also drives the serial output.

During a shift, the first stage does not take a plain data bit. It takes its new value from two serial control inputs that follow JK flip-flop rules: 00 keeps the current value, 10 forces a one, 01 forces a zero and 11 inverts it. An active-low clear empties every stage as soon as it is asserted, without waiting for a clock edge. The clear outranks both load and shift.

The mode input is decoded into a named operation, which is either LOAD or SHIFT. There are no other states. When `shift_nload` is 0 the operation is LOAD. When it is 1 the operation is SHIFT. The clear overrides the operation in both cases. The number of stages is set by the parameter `WIDTH`, which defaults to 4.

Top module: `jkshift_reg`

## Requirements
- R1: When `clr_n` falls, `par_q` becomes all zeros at once, with no clock edge needed. After a period of clear, `par_q` is zero at the first edge that samples `clr_n` high.
- R2: While `clr_n` is low, rising clock edges leave `par_q` at zero, whatever the mode and data inputs are.
- R3: With `shift_nload` = 0, a rising edge copies `par_d[i]` into `par_q[i]` for every stage at the same time.
- R4: With `shift_nload` = 1, a rising edge sets `par_q[i]` to the old `par_q[i-1]` for every i from 1 to WIDTH-1.
- R5: During a shift with `j_in`=0 and `k_in`=0, `par_q[0]` keeps its old value.
- R6: During a shift with `j_in`=1 and `k_in`=0, `par_q[0]` becomes 1.
- R7: During a shift with `j_in`=0 and `k_in`=1, `par_q[0]` becomes 0.
- R8: During a shift with `j_in`=1 and `k_in`=1, `par_q[0]` becomes the inverse of its old value.
- R9: `ser_out` always equals the last stage, `par_q[WIDTH-1]`.
- R10: Take a parallel load of `par_d` = 4'b1010, followed by four shifts with J=K=0. Then `ser_out` shows the loaded bits 3, 2, 1 and 0, one per clock. These appear after the load and after the first three shifts. After the fourth shift, `par_q` = 4'b0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; load and shift act on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_nload | input | 1 | Mode: 0 = parallel load, 1 = shift toward the last stage |
| j_in | input | 1 | Serial J input for the first stage |
| k_in | input | 1 | Serial K input for the first stage |
| par_d | input | WIDTH | Parallel data; bit i goes to stage i |
| par_q | output | WIDTH | Stage outputs; bit 0 is the first stage |
| ser_out | output | 1 | Serial output, taken from the last stage |

## Verification
The clear and a clocked load can fall in the same cycle, because the clear does not wait for the clock.

The bench provokes this in two steps. First it loads all ones. Then it drops `clr_n` in the middle of a clock period, with load selected and all-ones data still present. The outputs are checked before the next edge, which shows that the clear acted at once. They are checked again after two more edges, which shows that the edges did not reload the data.

A second overlap is between the JK rules and the shift path within one edge. Here the bench checks that stage 0 follows the JK table while the other stages move, and that toggles and holds are applied to both starting values.

// File: rtl/jkshift_pkg.sv
package jkshift_pkg;

    // Operation selected by the mode level
    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_SHIFT = 1'b1
    } op_e;

    // First-stage action, encoded as {j, k}
    typedef enum logic [1:0] {
        JK_HOLD   = 2'b00,
        JK_RESET  = 2'b01,
        JK_SET    = 2'b10,
        JK_TOGGLE = 2'b11
    } jk_act_e;

endpackage

// File: rtl/jkshift_mode_dec.sv
module jkshift_mode_dec
    import jkshift_pkg::*;
(
    input  logic shift_nload,
    output op_e  op
);

    always_comb begin
        unique case (shift_nload)
            1'b0:    op = OP_LOAD;
            default: op = OP_SHIFT;
        endcase
    end

endmodule

// File: rtl/jkshift_jk_entry.sv
module jkshift_jk_entry
    import jkshift_pkg::*;
(
    input  logic j_in,
    input  logic k_in,
    input  logic cur_q,
    output logic nxt_q
);

    jk_act_e act;

    always_comb begin
        act = jk_act_e'({j_in, k_in});
        unique case (act)
            JK_HOLD:   nxt_q = cur_q;
            JK_RESET:  nxt_q = 1'b0;
            JK_SET:    nxt_q = 1'b1;
            JK_TOGGLE: nxt_q = ~cur_q;
            default:   nxt_q = cur_q;
        endcase
    end

endmodule

// File: rtl/jkshift_stage.sv
module jkshift_stage
    import jkshift_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  op_e  op,
    input  logic load_bit,
    input  logic shift_bit,
    output logic q
);

    // Clear is asynchronous and wins over any clocked operation
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else begin
            unique case (op)
                OP_LOAD:  q <= load_bit;
                OP_SHIFT: q <= shift_bit;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/jkshift_reg.sv
module jkshift_reg
    import jkshift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             shift_nload,
    input  logic             j_in,
    input  logic             k_in,
    input  logic [WIDTH-1:0] par_d,
    output logic [WIDTH-1:0] par_q,
    output logic             ser_out
);

    localparam int LAST = WIDTH - 1;

    op_e              op;
    logic             first_nxt;
    logic [WIDTH-1:0] q_w;
    logic [WIDTH-1:0] shift_in;

    jkshift_mode_dec u_mode (
        .shift_nload (shift_nload),
        .op          (op)
    );

    jkshift_jk_entry u_jk (
        .j_in  (j_in),
        .k_in  (k_in),
        .cur_q (q_w[0]),
        .nxt_q (first_nxt)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign shift_in[i] = first_nxt;
        end else begin : g_body
            assign shift_in[i] = q_w[i-1];
        end

        jkshift_stage u_stage (
            .clk       (clk),
            .clr_n     (clr_n),
            .op        (op),
            .load_bit  (par_d[i]),
            .shift_bit (shift_in[i]),
            .q         (q_w[i])
        );
    end

    assign par_q   = q_w;
    assign ser_out = q_w[LAST];

endmodule

// File: rtl/jkshift_reg_chk.sv
module jkshift_reg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             shift_nload,
    input logic             j_in,
    input logic             k_in,
    input logic [WIDTH-1:0] par_d,
    input logic [WIDTH-1:0] par_q,
    input logic             ser_out
);

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
        $rose(clr_n) |-> par_q == '0); // R1

    AST_LOAD_ALL: assert property (@(posedge clk) disable iff (!clr_n)
        !shift_nload |=> par_q == $past(par_d)); // R3

    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!clr_n)
        shift_nload |=> par_q[WIDTH-1:1] == $past(par_q[WIDTH-2:0])); // R4

    AST_JK_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_nload && !j_in && !k_in) |=> par_q[0] == $past(par_q[0])); // R5

    AST_JK_SET: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_nload && j_in && !k_in) |=> par_q[0]); // R6

    AST_JK_RESET: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_nload && !j_in && k_in) |=> !par_q[0]); // R7

    AST_JK_TOGGLE: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_nload && j_in && k_in) |=> par_q[0] != $past(par_q[0])); // R8

    AST_SER_FOLLOW: assert property (@(posedge clk) disable iff (!clr_n)
        shift_nload |=> ser_out == $past(par_q[WIDTH-2])); // R9

endmodule

bind jkshift_reg jkshift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .clr_n       (clr_n),
    .shift_nload (shift_nload),
    .j_in        (j_in),
    .k_in        (k_in),
    .par_d       (par_d),
    .par_q       (par_q),
    .ser_out     (ser_out)
);

// File: tb/jkshift_reg_tb.sv
`timescale 1ns/1ps
module jkshift_reg_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         shift_nload = 1'b0;
    logic         j_in = 1'b0;
    logic         k_in = 1'b0;
    logic [W-1:0] par_d = '0;
    logic [W-1:0] par_q;
    logic         ser_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    jkshift_reg #(.WIDTH(W)) u_dut (
        .clk         (clk),
        .clr_n       (clr_n),
        .shift_nload (shift_nload),
        .j_in        (j_in),
        .k_in        (k_in),
        .par_d       (par_d),
        .par_q       (par_q),
        .ser_out     (ser_out)
    );

    always #2.5 clk = ~clk;

    // Vector: {shift_nload, j, k, par_d[3:0], expected par_q[3:0]}
    localparam int NV = 15;
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 4'b1010, 4'b1010},  // load 1010        R3 R10
        {1'b1, 1'b0, 1'b0, 4'b0000, 4'b0100},  // shift hold       R10
        {1'b1, 1'b0, 1'b0, 4'b0000, 4'b1000},  // shift hold       R10
        {1'b1, 1'b0, 1'b0, 4'b0000, 4'b0000},  // shift hold       R10
        {1'b1, 1'b0, 1'b0, 4'b0000, 4'b0000},  // shift hold, end  R10
        {1'b1, 1'b1, 1'b0, 4'b0000, 4'b0001},  // set              R6
        {1'b1, 1'b0, 1'b0, 4'b0000, 4'b0011},  // hold a one       R5
        {1'b1, 1'b1, 1'b1, 4'b0000, 4'b0110},  // toggle 1->0      R8
        {1'b1, 1'b1, 1'b1, 4'b0000, 4'b1101},  // toggle 0->1      R8
        {1'b1, 1'b0, 1'b1, 4'b0000, 4'b1010},  // reset from 1     R7
        {1'b1, 1'b0, 1'b1, 4'b0000, 4'b0100},  // reset from 0     R7
        {1'b1, 1'b1, 1'b0, 4'b1111, 4'b1001},  // set, data unused R6
        {1'b1, 1'b1, 1'b0, 4'b0000, 4'b0011},  // set from 1       R6
        {1'b0, 1'b1, 1'b1, 4'b0110, 4'b0110},  // load, jk unused  R3
        {1'b0, 1'b0, 1'b0, 4'b1111, 4'b1111}   // load all ones    R3
    };

    function automatic string row_tag(input logic shl, input logic j, input logic k);
        if (!shl) return "R3";
        case ({j, k})
            2'b00:   return "R4/R5";
            2'b10:   return "R4/R6";
            2'b01:   return "R4/R7";
            default: return "R4/R8";
        endcase
    endfunction

    task automatic check_q(input string tag, input logic [W-1:0] exp);
        total++;
        if (par_q !== exp) begin
            bad++;
            $display("FAIL %s par_q actual=%b expected=%b", tag, par_q, exp);
        end
    endtask

    task automatic check_ser(input string tag, input logic exp);
        total++;
        if (ser_out !== exp) begin
            bad++;
            $display("FAIL %s ser_out actual=%b expected=%b", tag, ser_out, exp);
        end
    endtask

    initial begin
        logic [10:0] v;
        logic [3:0]  loaded;

        // Reset state, clear held low from time zero
        #1;
        check_q("R1 reset", '0);
        repeat (2) @(posedge clk);
        #1;
        check_q("R1 reset held", '0);
        @(negedge clk);
        clr_n = 1'b1;

        // Table walk
        for (int n = 0; n < NV; n++) begin
            v = VEC[n];
            @(negedge clk);
            shift_nload = v[10];
            j_in        = v[9];
            k_in        = v[8];
            par_d       = v[7:4];
            @(posedge clk);
            #1;
            check_q(row_tag(v[10], v[9], v[8]), v[3:0]);
            check_ser("R9", v[3]);
            if (n < 5) check_q("R10", v[3:0]);
        end

        // Serial order after load 1010 (R10): bits 3,2,1,0 on ser_out
        loaded = 4'b1010;
        @(negedge clk);
        shift_nload = 1'b0; par_d = loaded; j_in = 1'b0; k_in = 1'b0;
        @(posedge clk);
        #1;
        check_ser("R10 bit3", loaded[3]);
        @(negedge clk);
        shift_nload = 1'b1;
        for (int b = 2; b >= 0; b--) begin
            @(posedge clk);
            #1;
            check_ser("R10 serial order", loaded[b]);
        end
        @(posedge clk);
        #1;
        check_q("R10 final", 4'b0000);

        // Async clear in mid-cycle, then edges under clear (R1, R2)
        @(negedge clk);
        shift_nload = 1'b0; par_d = 4'b1111;
        @(posedge clk);
        #1;
        check_q("R3 preload", 4'b1111);
        @(negedge clk);
        #0.5;
        clr_n = 1'b0;
        #0.5;
        check_q("R1 async", 4'b0000);
        repeat (2) @(posedge clk);
        #1;
        check_q("R2 load ignored", 4'b0000);
        @(negedge clk);
        shift_nload = 1'b1; j_in = 1'b1; k_in = 1'b0;
        @(posedge clk);
        #1;
        check_q("R2 shift ignored", 4'b0000);
        @(negedge clk);
        clr_n = 1'b1;
        @(posedge clk);
        #1;
        check_q("R6 after clear", 4'b0001);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule